// File: doc/BRIEF.md
# Clock-Synchronous Byte Serial Transceiver

This block moves one byte at a time over a three-wire synchronous serial link: a shift clock, a data output and a data input. Transmit and receive always run together on the same shift clock. Each clock period moves one bit out and one bit in, least-significant bit first. A host talks to the block over a small register bus with four addresses. Writing the data address queues a byte for transmission and starts a transfer. Reading the same address returns the last byte received.

The shift clock can come from inside the block or from outside. Internally, the system clock passes through an optional divide-by-four stage, then a programmable divide-by-(n+1) stage, then a toggle stage, which gives bit rates from 1/2 down to 1/2048 of the system clock. In external mode, a pin clock is synchronized and its edges drive the shifting. A pending-byte buffer allows continuous streaming. If a byte is written while a shift is still running, the next byte follows without a gap. Two transmit flags are kept: buffer empty and shift complete. Either one can be chosen as the source of the transmit interrupt. The receive path raises a buffer-full flag, a receive interrupt and an overrun flag. A ready output tells the remote side when a byte can be accepted.

Top module: `sync_serial_unit`

## Requirements
- R1: After reset, status reads 0x03 (bit 0 buffer-empty = 1, bit 1 shift-complete = 1, bit 2 receive-full = 0, bit 3 overrun = 0). The shift clock and serial output are high, and both interrupts and the ready output are low.
- R2: With the internal clock selected (control bit 0 = 0), one bit takes 2*(n+1) system clocks, where n is the value at address 3. Setting control bit 1 multiplies this by 4. The shift clock stays high whenever no transfer is running.
- R3: Writing address 0 clears buffer-empty. If no shift is running, the byte moves into the shift register in the following cycle and buffer-empty returns to 1.
- R4: Shift-complete (status bit 1) reads 0 while a byte is being shifted. It becomes 1 after the last bit when no further byte is pending.
- R5: Bits leave bit 0 first. The output changes on each falling shift-clock edge, and the input is sampled on each rising edge.
- R6: With receive enabled (control bit 3), the eighth sampled bit completes a byte. The byte is placed in the receive buffer (read at address 0), receive-full is set and the receive interrupt pulses for one cycle. Reading address 0 clears receive-full.
- R7: A byte that completes while receive-full is 1 sets overrun, replaces the buffer contents and gives no new receive interrupt. Writing address 2 with bit 3 set clears overrun.
- R8: The ready output equals receive-enable AND NOT receive-full.
- R9: The transmit interrupt pulses for one cycle when the selected flag goes from 0 to 1. Control bit 2 = 0 selects buffer-empty and 1 selects shift-complete.
- R10: A byte written during a running shift follows the current byte with no gap. Every bit period in the stream has the same length.
- R11: With control bit 0 = 1, falling edges of the synchronized clock input shift data out and rising edges sample data in, and the shift clock output stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 status, 3 divider |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Internal shift clock, idles high |
| sdata_in | input | 1 | Serial data input |
| sdata_out | output | 1 | Serial data output |
| rx_ready | output | 1 | Ready to accept a received byte |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
Several properties are checked on every cycle. Shift-complete never coexists with a running shift. A pending byte is always loaded when the shifter is idle. A pending byte at the end of a byte keeps the shifter running. The shift clock stays high while idle or in external mode. Every completed byte sets receive-full, and sets overrun when it lands on a full buffer. Only the directed scenarios can show the rest: the actual bit order on the wire, the exact bit period for a given divider and prescaler, gap-free streaming across a byte boundary, interrupt pulse counts per source selection, and correct shifting under an external clock.

// File: rtl/ssu_pkg.sv
package ssu_pkg;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_DIV  = 2'd3;

    localparam int OVR_CLR_BIT = 3;

    typedef struct packed {
        logic rx_en;
        logic irq_on_tsc;
        logic pre_div;
        logic ext_clk;
    } ctrl_t;

    typedef struct packed {
        logic ovr;
        logic rbf;
        logic tsc;
        logic tbe;
    } stat_t;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2
    } sedge_e;

    function automatic logic [7:0] pad_nibble(input logic [3:0] v);
        return {4'b0000, v};
    endfunction

endpackage

// File: rtl/ssu_clkgen.sv
module ssu_clkgen
    import ssu_pkg::*;
#(
    parameter int DW          = 8,
    parameter int PRE_RATIO   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          ext_sel,
    input  logic          pre_en,
    input  logic [DW-1:0] reload,
    input  logic          sclk_in,
    output logic          sclk_out,
    output sedge_e        edge_o
);
    localparam int PRE_W = $clog2(PRE_RATIO);

    logic [SYNC_STAGES:0] sync_q;
    logic [PRE_W-1:0]     pre_q;
    logic [DW-1:0]        div_q;
    logic                 tog_q;
    logic                 pre_hit;
    logic                 tick;
    logic                 ext_cur;
    logic                 ext_prev;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-1:0], sclk_in};
    end

    assign ext_cur  = sync_q[SYNC_STAGES-1];
    assign ext_prev = sync_q[SYNC_STAGES];

    assign pre_hit = !pre_en || (pre_q == PRE_W'(PRE_RATIO - 1));
    assign tick    = run && !ext_sel && pre_hit && (div_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !run || ext_sel) begin
            pre_q <= '0;
            div_q <= reload;
            tog_q <= 1'b1;
        end else begin
            if (pre_en) pre_q <= pre_hit ? '0 : pre_q + 1'b1;
            else        pre_q <= '0;
            if (pre_hit) div_q <= (div_q == '0) ? reload : div_q - 1'b1;
            if (tick)    tog_q <= ~tog_q;
        end
    end

    always_comb begin
        edge_o = EDGE_NONE;
        if (ext_sel) begin
            if (ext_prev && !ext_cur)      edge_o = EDGE_FALL;
            else if (!ext_prev && ext_cur) edge_o = EDGE_RISE;
        end else if (tick) begin
            edge_o = tog_q ? EDGE_FALL : EDGE_RISE;
        end
    end

    assign sclk_out = tog_q;

    // R2: no transfer running means the clock is parked high next cycle
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> sclk_out);

endmodule

// File: rtl/ssu_core.sv
module ssu_core
    import ssu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_buf,
    input  logic [DW-1:0] wdata,
    input  sedge_e        edge_i,
    input  logic          sdata_in,
    output logic          sdata_out,
    output logic          active,
    output logic          tbe,
    output logic          tsc,
    output logic          done,
    output logic [DW-1:0] rx_byte
);
    localparam int CW = $clog2(DW);

    logic [DW-1:0] tx_buf;
    logic [DW-1:0] tx_sh;
    logic [DW-1:0] rx_sh;
    logic [CW-1:0] cnt;
    logic          load;

    assign done    = active && (edge_i == EDGE_RISE) && (cnt == CW'(DW - 1));
    assign load    = !tbe && (!active || done);
    assign rx_byte = {sdata_in, rx_sh[DW-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf    <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            cnt       <= '0;
            active    <= 1'b0;
            tbe       <= 1'b1;
            tsc       <= 1'b1;
            sdata_out <= 1'b1;
        end else begin
            if (active && edge_i == EDGE_FALL) begin
                sdata_out <= tx_sh[0];
                tx_sh     <= tx_sh >> 1;
            end
            if (active && edge_i == EDGE_RISE) begin
                rx_sh <= rx_byte;
                cnt   <= cnt + 1'b1;
            end
            if (load) begin
                tx_sh  <= tx_buf;
                tbe    <= 1'b1;
                active <= 1'b1;
                tsc    <= 1'b0;
                cnt    <= '0;
            end else if (done) begin
                active <= 1'b0;
                tsc    <= 1'b1;
            end
            if (wr_buf) begin
                tx_buf <= wdata;
                tbe    <= 1'b0;
            end
        end
    end

    // R4: shift-complete is never reported while bits are moving
    p_tsc_idle_r4: assert property (@(posedge clk) disable iff (rst)
        tsc |-> !active);

    // R3: an idle shifter takes a pending byte at once
    p_load_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!tbe && !active && !wr_buf) |=> (tbe && active));

    // R10: a pending byte at the byte boundary keeps the shifter running
    p_no_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (done && !tbe) |=> active);

endmodule

// File: rtl/sync_serial_unit.sv
module sync_serial_unit
    import ssu_pkg::*;
#(
    parameter int DW          = 8,
    parameter int PRE_RATIO   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          sclk_in,
    output logic          sclk_out,
    input  logic          sdata_in,
    output logic          sdata_out,
    output logic          rx_ready,
    output logic          tx_irq,
    output logic          rx_irq
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t         ctrl_q;
    logic [DW-1:0] div_q;
    logic [DW-1:0] rx_buf;
    logic          rbf, ovr;
    logic          rbf_d, tx_flag_d;
    logic          tx_flag;
    stat_t         stat;
    sedge_e        sedge;
    logic          active, tbe, tsc, done;
    logic [DW-1:0] rx_byte;
    logic          wr_data, wr_ctrl, wr_stat, wr_div, rd_data;

    assign wr_data = bus_wr && bus_addr == ADDR_DATA;
    assign wr_ctrl = bus_wr && bus_addr == ADDR_CTRL;
    assign wr_stat = bus_wr && bus_addr == ADDR_STAT;
    assign wr_div  = bus_wr && bus_addr == ADDR_DIV;
    assign rd_data = bus_rd && bus_addr == ADDR_DATA;

    ssu_clkgen #(.DW(DW), .PRE_RATIO(PRE_RATIO), .SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run      (active),
        .ext_sel  (ctrl_q.ext_clk),
        .pre_en   (ctrl_q.pre_div),
        .reload   (div_q),
        .sclk_in  (sclk_in),
        .sclk_out (sclk_out),
        .edge_o   (sedge)
    );

    ssu_core #(.DW(DW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .wr_buf    (wr_data),
        .wdata     (bus_wdata),
        .edge_i    (sedge),
        .sdata_in  (sdata_in),
        .sdata_out (sdata_out),
        .active    (active),
        .tbe       (tbe),
        .tsc       (tsc),
        .done      (done),
        .rx_byte   (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            div_q     <= '0;
            rx_buf    <= '0;
            rbf       <= 1'b0;
            ovr       <= 1'b0;
            rbf_d     <= 1'b0;
            tx_flag_d <= 1'b1;
        end else begin
            rbf_d     <= rbf;
            tx_flag_d <= tx_flag;
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_div)  div_q  <= bus_wdata;
            if (wr_stat && bus_wdata[OVR_CLR_BIT]) ovr <= 1'b0;
            if (rd_data) rbf <= 1'b0;
            if (done && ctrl_q.rx_en) begin
                rx_buf <= rx_byte;
                rbf    <= 1'b1;
                if (rbf) ovr <= 1'b1;
            end
        end
    end

    assign tx_flag  = ctrl_q.irq_on_tsc ? tsc : tbe;
    assign tx_irq   = tx_flag && !tx_flag_d;
    assign rx_irq   = rbf && !rbf_d;
    assign rx_ready = ctrl_q.rx_en && !rbf;

    assign stat = '{ovr: ovr, rbf: rbf, tsc: tsc, tbe: tbe};

    always_comb begin
        unique case (bus_addr)
            ADDR_DATA: bus_rdata = rx_buf;
            ADDR_CTRL: bus_rdata = pad_nibble(ctrl_q);
            ADDR_STAT: bus_rdata = pad_nibble(stat);
            default:   bus_rdata = div_q;
        endcase
    end

    // R6: every completed byte with receive enabled fills the buffer
    p_rbf_set_r6: assert property (@(posedge clk) disable iff (rst)
        (done && ctrl_q.rx_en) |=> rbf);

    // R7: a byte landing on a full buffer flags overrun
    p_ovr_set_r7: assert property (@(posedge clk) disable iff (rst)
        (done && ctrl_q.rx_en && rbf) |=> ovr);

    // R11: external clock mode leaves the clock output high
    p_ext_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.ext_clk |=> sclk_out);

endmodule

// File: tb/sync_serial_unit_test.sv
module sync_serial_unit_test;
    import ssu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sclk_in = 1'b1;
    logic       sclk_out, sdata_out, rx_ready, tx_irq, rx_irq;
    logic       loop = 1'b1;
    logic       ext_bit = 1'b0;
    logic       sdin;

    int total = 0;
    int bad   = 0;

    int          cyc = 0, last_rise = 0, rises = 0, min_iv = 0, max_iv = 0;
    int          tx_irqs = 0, rx_irqs = 0;
    logic        prev_sclk = 1'b1;
    logic [15:0] cap = '0;

    assign sdin = loop ? sdata_out : ext_bit;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_serial_unit uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sdata_in(sdin),
        .sdata_out(sdata_out), .rx_ready(rx_ready), .tx_irq(tx_irq),
        .rx_irq(rx_irq)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sclk_out && !prev_sclk) begin
            cap = {sdata_out, cap[15:1]};
            if (rises > 0) begin
                if (min_iv == 0 || cyc - last_rise < min_iv) min_iv = cyc - last_rise;
                if (cyc - last_rise > max_iv) max_iv = cyc - last_rise;
            end
            last_rise = cyc;
            rises = rises + 1;
        end
        prev_sclk = sclk_out;
        if (tx_irq) tx_irqs = tx_irqs + 1;
        if (rx_irq) rx_irqs = rx_irqs + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic clear_mon();
        #1;
        rises = 0; min_iv = 0; max_iv = 0; cap = '0;
        tx_irqs = 0; rx_irqs = 0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        bit seen = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4000 && !seen; i++) begin
            rd(ADDR_STAT, s);
            if (s[1]) seen = 1;
        end
        chk("R4 shift-complete reached", {31'd0, seen}, 32'd1);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        rd(ADDR_STAT, s);
        chk("R1 status after reset", {24'd0, s}, 32'h03);
        chk("R1 idle pins", {28'd0, sclk_out, sdata_out, rx_ready, tx_irq | rx_irq}, 32'b1100);
    endtask

    task automatic t_single();
        logic [7:0] s;
        loop = 1'b1;
        wr(ADDR_DIV, 8'd0);
        wr(ADDR_CTRL, 8'h0C);
        clear_mon();
        chk("R8 ready with empty buffer", {31'd0, rx_ready}, 32'd1);
        wr(ADDR_DATA, 8'hA5);
        rd(ADDR_STAT, s);
        chk("R3 buffer-empty cleared by write", {31'd0, s[0]}, 32'd0);
        rd(ADDR_STAT, s);
        chk("R3 buffer-empty after load", {31'd0, s[0]}, 32'd1);
        chk("R4 shift-complete low while shifting", {31'd0, s[1]}, 32'd0);
        wait_idle();
        chk("R5 wire byte lsb first", {24'd0, cap[15:8]}, 32'hA5);
        chk("R2 rising edge count", rises, 8);
        chk("R2 min bit period n=0", min_iv, 2);
        chk("R2 max bit period n=0", max_iv, 2);
        chk("R9 one tx irq on shift-complete", tx_irqs, 1);
        chk("R6 one rx irq", rx_irqs, 1);
        rd(ADDR_STAT, s);
        chk("R6 receive-full set, no overrun", {30'd0, s[3:2]}, 32'b01);
        chk("R8 not ready when full", {31'd0, rx_ready}, 32'd0);
        rd(ADDR_DATA, s);
        chk("R6 received byte", {24'd0, s}, 32'hA5);
        rd(ADDR_STAT, s);
        chk("R6 read clears receive-full", {31'd0, s[2]}, 32'd0);
        chk("R8 ready again", {31'd0, rx_ready}, 32'd1);
    endtask

    task automatic t_rate();
        logic [7:0] s;
        wr(ADDR_DIV, 8'd2);
        wr(ADDR_CTRL, 8'h0E);
        clear_mon();
        wr(ADDR_DATA, 8'h3C);
        wait_idle();
        chk("R2 min bit period n=2 pre4", min_iv, 24);
        chk("R2 max bit period n=2 pre4", max_iv, 24);
        chk("R5 wire byte prescaled", {24'd0, cap[15:8]}, 32'h3C);
        chk("R2 clock parked high", {31'd0, sclk_out}, 32'd1);
        rd(ADDR_DATA, s);
        chk("R6 received prescaled byte", {24'd0, s}, 32'h3C);
    endtask

    task automatic t_stream();
        logic [7:0] s;
        wr(ADDR_DIV, 8'd1);
        wr(ADDR_CTRL, 8'h08);
        clear_mon();
        wr(ADDR_DATA, 8'h96);
        repeat (3) @(negedge clk);
        wr(ADDR_DATA, 8'h4B);
        wait_idle();
        chk("R10 two bytes on the wire", {16'd0, cap}, 32'h4B96);
        chk("R10 sixteen bits", rises, 16);
        chk("R10 min bit period", min_iv, 4);
        chk("R10 max bit period", max_iv, 4);
        chk("R9 two tx irqs on buffer-empty", tx_irqs, 2);
        chk("R7 no second rx irq", rx_irqs, 1);
        rd(ADDR_STAT, s);
        chk("R7 overrun and full", {30'd0, s[3:2]}, 32'b11);
        rd(ADDR_DATA, s);
        chk("R7 newest byte kept", {24'd0, s}, 32'h4B);
        wr(ADDR_STAT, 8'h08);
        rd(ADDR_STAT, s);
        chk("R7 overrun cleared", {30'd0, s[3:2]}, 32'b00);
    endtask

    task automatic t_ext();
        logic [7:0] s;
        logic [7:0] txcap;
        localparam logic [7:0] RXB = 8'hD2;
        loop = 1'b0;
        wr(ADDR_CTRL, 8'h09);
        clear_mon();
        wr(ADDR_DATA, 8'h69);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sclk_in = 1'b0;
            ext_bit = RXB[i];
            repeat (6) @(negedge clk);
            txcap[i] = sdata_out;
            sclk_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        wait_idle();
        chk("R11 byte out on external clock", {24'd0, txcap}, 32'h69);
        chk("R11 clock output stayed high", rises, 0);
        rd(ADDR_DATA, s);
        chk("R11 byte in on external clock", {24'd0, s}, {24'd0, RXB});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_rate();
        t_stream();
        t_ext();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule